// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block times the clock line of an I2C master. A reloadable down-counter sets the length of each half of the SCL period. The block drives a pull-down request for an open-drain SCL pad. It also gives the master sequencer a one-cycle strobe at the start of every low half and every high half. The sequencer and the line model supply the synchronised level of SCL. The generator uses that level to honour clock stretching by a slave and clock synchronisation with other masters.

The counter is one-shot. After a load it counts down to zero and then waits there until the next phase loads it again.

- **Low half.** The counter loads when the low half begins. When it reaches zero the generator releases the line.
- **High half.** The generator waits until SCL actually reads high. Only then does it load the counter for the high half, so a device holding SCL low lengthens the period.
- **Early pull-down.** If SCL drops while the high half is still counting, another master has pulled it low. The generator starts its own low half at once.

A reload value of 0 or 1 is refused. In that case the error flag is raised and the line stays released. For a target rate, the reload value is roughly the system clock divided by twice the SCL rate, minus one. With a 9-bit reload value, a 20 MHz system clock reaches 100 kHz, 400 kHz and 1 MHz.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and on leaving reset, `scl_pull_o`, `low_start_o`, `high_start_o` and `err_o` are all 0.
- R2: With a legal reload value N and SCL following the pull request without delay, every low half lasts exactly N+1 cycles of `scl_pull_o`=1.
- R3: With a legal reload value N and SCL following the pull request without delay, every high half lasts exactly N+1 cycles of `scl_pull_o`=0.
- R4: After the line is released, the counter is not reloaded while `scl_i` reads 0. If SCL is held low for S cycles after release, the released time is S+N+1 cycles.
- R5: If `scl_i` reads 0 during a counting high half, `scl_pull_o` rises on the next clock. The low half that follows then lasts N+1 cycles.
- R6: Reload values 0 and 1 are illegal. With `en_i`=1 and an illegal value, `err_o` is 1 from the next clock and `scl_pull_o` stays 0. A legal value clears `err_o` on the next clock.
- R7: When `en_i` is 0, `scl_pull_o` is 0 from the next clock on.
- R8: `low_start_o` is 1 for exactly one cycle, the first cycle of each low half. `high_start_o` is 1 for exactly one cycle in each high half, the first cycle after SCL is seen high. The two are never 1 together.
- R9: Every reload value from 2 to 2^RELOAD_W-1 is legal and gives the timing of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the generator; 0 releases SCL and clears the counter |
| reload_i | input | RELOAD_W | Half-period reload value (legal range 2 and up) |
| scl_i | input | 1 | Synchronised level of the SCL line |
| scl_pull_o | output | 1 | 1 requests the pad to pull SCL low |
| low_start_o | output | 1 | Strobe in the first cycle of each low half |
| high_start_o | output | 1 | Strobe in the first counted cycle of each high half |
| err_o | output | 1 | Enabled with an illegal reload value |

## Verification
The assertions assume two things about the inputs. First, `scl_i` is already synchronised. Second, `scl_i` reads 0 whenever `scl_pull_o` is 1, since the pad can only be pulled low. The bench builds `scl_i` as a wired-AND of the block's own pull request and a second pull-down that stands in for a stretching slave or a competing master, so the line can never read high while the block pulls it. The bench changes `reload_i` only while `en_i` is 0 or while it is testing the illegal values, so no half period sees a mid-count change.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,  // released, waiting for line to read high
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_reload_chk.sv
module scl_reload_chk #(
  parameter int RELOAD_W = 9
) (
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                legal_o
);
  localparam logic [RELOAD_W-1:0] MinLegal = RELOAD_W'(2);

  assign legal_o = (reload_i >= MinLegal);
endmodule

// File: rtl/scl_bit_timer.sv
module scl_bit_timer #(
  parameter int RELOAD_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] load_val_i,
  input  logic                dec_i,
  output logic                zero_o
);
  logic [RELOAD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0))     cnt_q <= cnt_q - RELOAD_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // one-shot: once at zero, only a load moves it
  a_r4_zero_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

  a_r9_nonzero_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> !zero_o);
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_rate_pkg::*;
#(
  parameter int RELOAD_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                legal_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                scl_i,
  input  logic                zero_i,
  output logic                clr_o,
  output logic                load_o,
  output logic [RELOAD_W-1:0] load_val_o,
  output logic                dec_o,
  output logic                scl_pull_o,
  output logic                low_start_o,
  output logic                high_start_o,
  output logic                err_o
);
  scl_phase_e ph_q, ph_d;
  logic pull_q, low_st_q, high_st_q, err_q;

  always_comb begin
    ph_d       = ph_q;
    clr_o      = 1'b0;
    load_o     = 1'b0;
    load_val_o = reload_i;
    dec_o      = 1'b0;
    if (!en_i || !legal_i) begin
      ph_d  = PH_IDLE;
      clr_o = 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d   = PH_LOW;
          load_o = 1'b1;
        end
        PH_LOW: begin
          if (zero_i) ph_d = PH_WAIT;
          else        dec_o = 1'b1;
        end
        PH_WAIT: begin
          // first high sample already counts as one cycle of the half
          if (scl_i) begin
            ph_d       = PH_HIGH;
            load_o     = 1'b1;
            load_val_o = reload_i - RELOAD_W'(1);
          end
        end
        PH_HIGH: begin
          if (!scl_i || zero_i) begin
            ph_d   = PH_LOW;
            load_o = 1'b1;
          end else begin
            dec_o = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      pull_q    <= 1'b0;
      low_st_q  <= 1'b0;
      high_st_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      pull_q    <= (ph_d == PH_LOW);
      low_st_q  <= (ph_d == PH_LOW)  && (ph_q != PH_LOW);
      high_st_q <= (ph_d == PH_HIGH) && (ph_q != PH_HIGH);
      err_q     <= en_i && !legal_i;
    end
  end

  assign scl_pull_o   = pull_q;
  assign low_start_o  = low_st_q;
  assign high_start_o = high_st_q;
  assign err_o        = err_q;

  a_r6_err_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !scl_pull_o);

  a_r7_disable_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_pull_o);

  a_r5_yield_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HIGH && !scl_i && en_i && legal_i) |=> (scl_pull_o && low_start_o));

  a_r4_stretch_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT && !scl_i && en_i && legal_i) |=> (!scl_pull_o && !high_start_o));

  a_r8_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_start_o && high_start_o));

  a_r8_low_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_start_o |=> !low_start_o);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int RELOAD_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                scl_i,
  output logic                scl_pull_o,
  output logic                low_start_o,
  output logic                high_start_o,
  output logic                err_o
);
  logic                legal;
  logic                clr, load, dec, zero;
  logic [RELOAD_W-1:0] load_val;

  scl_reload_chk #(.RELOAD_W(RELOAD_W)) u_chk (
    .reload_i (reload_i),
    .legal_o  (legal)
  );

  scl_phase_ctl #(.RELOAD_W(RELOAD_W)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .legal_i      (legal),
    .reload_i     (reload_i),
    .scl_i        (scl_i),
    .zero_i       (zero),
    .clr_o        (clr),
    .load_o       (load),
    .load_val_o   (load_val),
    .dec_o        (dec),
    .scl_pull_o   (scl_pull_o),
    .low_start_o  (low_start_o),
    .high_start_o (high_start_o),
    .err_o        (err_o)
  );

  scl_bit_timer #(.RELOAD_W(RELOAD_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!scl_pull_o && !err_o && !low_start_o && !high_start_o));
endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] reload = W'(2);
  logic         ext_hold = 1'b0;
  logic         scl_line;
  logic         pull, low_st, high_st, err;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign scl_line = !pull && !ext_hold;  // wired-AND open drain

  scl_rate_gen #(.RELOAD_W(W)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .reload_i     (reload),
    .scl_i        (scl_line),
    .scl_pull_o   (pull),
    .low_start_o  (low_st),
    .high_start_o (high_st),
    .err_o        (err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count cycles while pull equals lvl; also counts high strobes seen
  task automatic run_len(input logic lvl, output int n, output int hs);
    n = 0; hs = 0;
    while (pull == lvl && n < 4000) begin
      n++;
      if (high_st) hs++;
      @(negedge clk);
    end
  endtask

  task automatic wait_pull(input logic lvl);
    for (int i = 0; i < 20 && pull != lvl; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    en = 1'b0;
    ext_hold = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic start(input int r);
    reload = W'(r);
    en = 1'b1;
    @(negedge clk);
    wait_pull(1'b1);
    check(low_st == 1'b1, "R8 low strobe at start", int'(low_st), 1);
  endtask

  task automatic sweep(input int r);
    int n, hs;
    start(r);
    run_len(1'b1, n, hs);
    check(n == r + 1, "R2/R9 low half", n, r + 1);
    run_len(1'b0, n, hs);
    check(n == r + 1, "R3/R9 high half", n, r + 1);
    check(hs == 1, "R8 one high strobe", hs, 1);
    check(low_st == 1'b1, "R8 low strobe repeat", int'(low_st), 1);
    run_len(1'b1, n, hs);
    check(n == r + 1, "R2 second low half", n, r + 1);
    go_idle();
  endtask

  task automatic stretch(input int r, input int s);
    int n, hs, m;
    start(r);
    run_len(1'b1, n, hs);
    n = 0; hs = 0;
    ext_hold = 1'b1;
    repeat (s) begin
      n++;
      if (high_st) hs++;
      @(negedge clk);
    end
    ext_hold = 1'b0;
    run_len(1'b0, m, n);  // reuse: m = rest, n reused as strobe count below
    hs += n;
    n = s + m;
    check(n == s + r + 1, "R4 stretched high", n, s + r + 1);
    check(hs == 1, "R4/R8 strobe after stretch", hs, 1);
    go_idle();
  endtask

  task automatic yield_test(input int r, input int k);
    int n, hs;
    start(r);
    run_len(1'b1, n, hs);
    repeat (k) @(negedge clk);  // k >= 1 so high half is counting
    check(pull == 1'b0, "R5 still high before pull", int'(pull), 0);
    ext_hold = 1'b1;
    @(negedge clk);
    check(pull == 1'b1, "R5 pull next clock", int'(pull), 1);
    check(low_st == 1'b1, "R5 low strobe", int'(low_st), 1);
    ext_hold = 1'b0;
    run_len(1'b1, n, hs);
    check(n == r + 1, "R5 full low half", n, r + 1);
    go_idle();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    int n, hs;
    repeat (3) @(negedge clk);
    check(pull == 1'b0 && err == 1'b0 && low_st == 1'b0 && high_st == 1'b0,
          "R1 in reset", int'({pull, err, low_st, high_st}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pull == 1'b0 && err == 1'b0, "R1 after reset", int'({pull, err}), 0);

    for (int r = 2; r <= 12; r++) sweep(r);
    sweep(100);
    sweep(255);
    sweep(511);

    for (int r = 2; r <= 9; r += 7)
      for (int s = 1; s <= 7; s += 2) stretch(r, s);

    yield_test(4, 1);
    yield_test(6, 3);
    yield_test(10, 9);

    // R6 illegal values
    for (int v = 0; v <= 1; v++) begin
      reload = W'(v);
      en = 1'b1;
      @(negedge clk);
      check(err == 1'b1, "R6 err raised", int'(err), 1);
      n = 0;
      repeat (6) begin
        if (pull) n++;
        @(negedge clk);
      end
      check(n == 0, "R6 line released", n, 0);
      reload = W'(3);
      @(negedge clk);
      check(err == 1'b0, "R6 err cleared", int'(err), 0);
      go_idle();
    end

    // R7 disable mid low half and mid high half
    start(20);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(pull == 1'b0, "R7 release in low half", int'(pull), 0);
    n = 0;
    repeat (30) begin
      if (pull) n++;
      @(negedge clk);
    end
    check(n == 0, "R7 stays released", n, 0);
    start(5);
    run_len(1'b1, n, hs);
    en = 1'b0;
    @(negedge clk);
    check(pull == 1'b0, "R7 release in high half", int'(pull), 0);
    en = 1'b1;
    @(negedge clk);
    check(pull == 1'b1 && low_st == 1'b1, "R7 restart from cleared",
          int'({pull, low_st}), 3);
    run_len(1'b1, n, hs);
    check(n == 6, "R7 fresh low half", n, 6);
    go_idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule